// File: doc/BRIEF.md
# Row Overhead Timing Generator

This block times the overhead interval that comes before each row of an image-sensor readout. It runs on a fast master clock. It derives a sensor clock with a period of four master cycles and measures every interval in whole sensor clocks. Each time a row-start strobe arrives while the generator is idle, it opens a window that begins on the next sensor-clock boundary. At the start of that window it raises a column-line precharge pulse. It signals the final master cycle of the window with a one-cycle done strobe.

Two write-only settings drive the block. The first is an 8-bit control word with these fields:
- bit 0: power-down request.
- bit 1: run enable. While this bit is 0 the sequencer is held in reset.
- bit 2: window-length mode.
- bits 5:4: precharge-width code.

The second is a 5-bit length value N. In short mode the window lasts N+2 sensor clocks. In long mode it lasts a fixed 35 sensor clocks. The precharge pulse width is taken from the width code and never changes the window length. Settings are captured once, when a window begins, so writes made during a window affect only the next one.

Top module: `rot_timing_gen`

## Requirements
- R1: After reset, every output is 0, the control word reads as 0 and the length value is 7. The first short-mode window therefore lasts 9 sensor clocks (36 master cycles) with a 1-sensor-clock precharge.
- R2: A window always opens and closes on a sensor-clock boundary (sensor clock = 4 master cycles). A row-start strobe accepted while idle opens the window within 3 master cycles after the cycle in which the strobe is sampled.
- R3: With control bit 2 = 1 (short mode), the window is high for (N+2)*4 master cycles, where N is the 5-bit length value.
- R4: With control bit 2 = 0 (long mode), the window is high for 140 master cycles, whatever the length value.
- R5: Only bits 4:0 of a length-value write are kept. Control bits 7:6 and bit 3 have no effect on the window, the precharge or the power-down output.
- R6: The precharge output rises together with the window and is high for 1, 2 or 3 sensor clocks for width codes 00, 01 and 10. Code 11 acts as 10. The width never changes the window length.
- R7: While control bit 1 is 0, no window starts. Clearing the bit during a window ends that window within one master cycle, with no done strobe.
- R8: The power-down output equals control bit 0 from the cycle after the write.
- R9: A row-start strobe that arrives while a window is active is dropped and opens no later window.
- R10: The done output is high for exactly one master cycle, the last cycle of each completed window.
- R11: Writes to either setting made during a window change neither that window's length nor its precharge width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word: bit0 power-down, bit1 run, bit2 short mode, bits5:4 precharge width |
| tmr_wr | input | 1 | Write strobe for the length value |
| tmr_wdata | input | 8 | Length value N in bits 4:0; bits 7:5 are ignored |
| row_start | input | 1 | Per-row request to open a window |
| rot_active | output | 1 | High for the duration of the overhead window |
| precharge | output | 1 | Column-line precharge pulse at the start of the window |
| power_down | output | 1 | Power-down request to the image core |
| rot_done | output | 1 | One-cycle strobe on the last cycle of a window |

## Verification
The bench builds the block with its default parameters: a 4-cycle sensor clock, a 5-bit length value and a 35-sensor-clock long window. With these values every length can be reached within a short run: the minimum of 8 master cycles, the reset value of 36, the longest short window of 132 and the 140-cycle long window. A behavioural model tracks the divider phase, so each strobe lands at some offset from a sensor boundary, and start latency is checked against those phases. The run also covers writes made mid-window, a strobe dropped during a window, and an abort.

// File: rtl/rot_pkg.sv
// Package: shared types and helpers for the row overhead timing generator.
// Assumes an 8-bit control word whose field layout is fixed by rot_ctrl_t.
package rot_pkg;

    localparam int CTRL_W = 8;

    // Control word layout, MSB first
    typedef struct packed {
        logic [1:0] spare;
        logic [1:0] pre_code;
        logic       dual_slope;
        logic       short_mode;
        logic       run;
        logic       pwr_down;
    } rot_ctrl_t;

    // Precharge width in sensor clocks for a 2-bit code; code 3 aliases code 2
    function automatic logic [1:0] pre_sclks(input logic [1:0] code);
        case (code)
            2'b00:   pre_sclks = 2'd1;
            2'b01:   pre_sclks = 2'd2;
            default: pre_sclks = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/rot_cfg_regs.sv
// Module: holds the control word and the length value written by the host.
// Assumes write strobes are single-cycle and synchronous to clk. Keeps only
// the fields the timing logic uses; every other written bit is dropped.
module rot_cfg_regs
    import rot_pkg::*;
#(
    parameter int TMR_W   = 5,
    parameter int TMR_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tmr_wr,
    input  logic [CTRL_W-1:0] tmr_wdata,
    output logic              pwr_down_q,
    output logic              run_q,
    output logic              short_q,
    output logic [1:0]        pre_code_q,
    output logic [TMR_W-1:0]  tmr_q
);

    rot_ctrl_t wr_word;
    logic      unused_bits;

    assign wr_word     = rot_ctrl_t'(ctrl_wdata);
    assign unused_bits = ^{wr_word.spare, wr_word.dual_slope, tmr_wdata[CTRL_W-1:TMR_W]};

    // Control fields: cleared at reset, loaded on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down_q <= 1'b0;
            run_q      <= 1'b0;
            short_q    <= 1'b0;
            pre_code_q <= 2'b00;
        end else if (ctrl_wr) begin
            pwr_down_q <= wr_word.pwr_down;
            run_q      <= wr_word.run;
            short_q    <= wr_word.short_mode;
            pre_code_q <= wr_word.pre_code;
        end
    end

    // Length value: reset constant, low TMR_W bits loaded on a length write
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= TMR_W'(TMR_RST);
        else if (tmr_wr)
            tmr_q <= tmr_wdata[TMR_W-1:0];
    end

endmodule

// File: rtl/rot_phase_div.sv
// Module: divides the master clock down to sensor-clock phases.
// Assumes DIV >= 2. Held at phase 0 while clr is high, so counting resumes
// from a known boundary once clr drops.
module rot_phase_div #(
    parameter int DIV  = 4,
    parameter int PH_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [PH_W-1:0] phase,
    output logic            sclk_last
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    assign sclk_last = (phase == PH_LAST);

    // Phase counter: wraps at DIV-1, forced to zero by reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            phase <= '0;
        else if (sclk_last)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/rot_window.sv
// Module: sequences one overhead window per accepted row-start strobe.
// Assumes sclk_last marks the final master cycle of each sensor clock. A strobe
// taken while idle is held until the next boundary. Length and precharge width
// are latched when the window opens.
module rot_window
    import rot_pkg::*;
#(
    parameter int TMR_W     = 5,
    parameter int LONG_SCLK = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             short_mode,
    input  logic [TMR_W-1:0] tmr,
    input  logic [1:0]       pre_code,
    input  logic             row_start,
    input  logic             sclk_last,
    output logic             active,
    output logic             precharge,
    output logic             done
);

    localparam int SHORT_MAX = (1 << TMR_W) + 1;
    localparam int MAX_LEN   = (LONG_SCLK > SHORT_MAX) ? LONG_SCLK : SHORT_MAX;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    logic             pending;
    logic [CNT_W-1:0] sidx;
    logic [CNT_W-1:0] len_l;
    logic [1:0]       pre_l;
    logic [CNT_W-1:0] len_next;
    logic             go;
    logic             at_end;

    assign len_next  = short_mode ? (CNT_W'(tmr) + CNT_W'(2)) : CNT_W'(LONG_SCLK);
    assign go        = run && !active && (pending || row_start) && sclk_last;
    assign at_end    = (sidx == len_l - 1'b1);
    assign precharge = active && (sidx < CNT_W'(pre_l));
    assign done      = active && sclk_last && at_end;

    // Window sequencer: idle/pending/active with sensor-clock index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pending <= 1'b0;
            sidx    <= '0;
            len_l   <= '0;
            pre_l   <= 2'd0;
        end else if (!run) begin
            active  <= 1'b0;
            pending <= 1'b0;
            sidx    <= '0;
        end else if (active) begin
            if (sclk_last) begin
                if (at_end) begin
                    active <= 1'b0;
                    sidx   <= '0;
                end else begin
                    sidx <= sidx + 1'b1;
                end
            end
        end else if (go) begin
            active  <= 1'b1;
            pending <= 1'b0;
            sidx    <= '0;
            len_l   <= len_next;
            pre_l   <= pre_sclks(pre_code);
        end else if (row_start) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/rot_timing_gen.sv
// Module: top of the row overhead timing generator.
// Assumes all inputs are synchronous to clk. Connects the setting registers,
// the sensor-clock divider and the window sequencer; the divider is cleared
// whenever the run bit is low.
module rot_timing_gen
    import rot_pkg::*;
#(
    parameter int SCLK_DIV  = 4,
    parameter int TMR_W     = 5,
    parameter int TMR_RST   = 7,
    parameter int LONG_SCLK = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tmr_wr,
    input  logic [CTRL_W-1:0] tmr_wdata,
    input  logic              row_start,
    output logic              rot_active,
    output logic              precharge,
    output logic              power_down,
    output logic              rot_done
);

    localparam int PH_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

    logic             run_q;
    logic             short_q;
    logic [1:0]       pre_code_q;
    logic [TMR_W-1:0] tmr_q;
    logic [PH_W-1:0]  phase_q;
    logic             sclk_last;

    rot_cfg_regs #(
        .TMR_W   (TMR_W),
        .TMR_RST (TMR_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .tmr_wr     (tmr_wr),
        .tmr_wdata  (tmr_wdata),
        .pwr_down_q (power_down),
        .run_q      (run_q),
        .short_q    (short_q),
        .pre_code_q (pre_code_q),
        .tmr_q      (tmr_q)
    );

    rot_phase_div #(
        .DIV  (SCLK_DIV),
        .PH_W (PH_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!run_q),
        .phase     (phase_q),
        .sclk_last (sclk_last)
    );

    rot_window #(
        .TMR_W     (TMR_W),
        .LONG_SCLK (LONG_SCLK)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .short_mode (short_q),
        .tmr        (tmr_q),
        .pre_code   (pre_code_q),
        .row_start  (row_start),
        .sclk_last  (sclk_last),
        .active     (rot_active),
        .precharge  (precharge),
        .done       (rot_done)
    );

endmodule

// File: rtl/rot_timing_chk.sv
// Module: property checker for rot_timing_gen, attached by bind below.
// Assumes phase is the divider count and run the registered run bit.
module rot_timing_chk #(
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic [PH_W-1:0] phase,
    input logic            rot_active,
    input logic            precharge,
    input logic            rot_done
);

    AST_DONE_INSIDE:   assert property (@(posedge clk) disable iff (!rst_n) rot_done |-> rot_active);           // R10
    AST_DONE_CLOSES:   assert property (@(posedge clk) disable iff (!rst_n) rot_done |=> !rot_active);          // R10
    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) rot_done |=> !rot_done);            // R10
    AST_PRE_INSIDE:    assert property (@(posedge clk) disable iff (!rst_n) precharge |-> rot_active);          // R6
    AST_PRE_LEADS:     assert property (@(posedge clk) disable iff (!rst_n) $rose(rot_active) |-> precharge);   // R6
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) $rose(rot_active) |-> phase == '0); // R2
    AST_END_ALIGNED:   assert property (@(posedge clk) disable iff (!rst_n) $fell(rot_active) |-> phase == '0); // R2
    AST_HALT_NO_ROT:   assert property (@(posedge clk) disable iff (!rst_n) !run |=> !rot_active);              // R7

endmodule

bind rot_timing_gen rot_timing_chk #(.PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .phase      (phase_q),
    .rot_active (rot_active),
    .precharge  (precharge),
    .rot_done   (rot_done)
);

// File: tb/sim_rot_timing_gen.sv
// Bench: directed scenarios plus a behavioural per-cycle model compared at
// every falling edge. Inputs change only on falling edges.
module sim_rot_timing_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic       row_start = 1'b0;
    logic       rot_active;
    logic       precharge;
    logic       power_down;
    logic       rot_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_timing_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .tmr_wr     (tmr_wr),
        .tmr_wdata  (tmr_wdata),
        .row_start  (row_start),
        .rot_active (rot_active),
        .precharge  (precharge),
        .power_down (power_down),
        .rot_done   (rot_done)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural model (master-cycle granularity) ----------------
    logic [7:0] m_ctrl = 8'h00;
    int m_tmr = 7;
    int m_phase = 0;
    bit m_pending = 0;
    bit m_active = 0;
    int m_idx = 0;
    int m_len = 0;
    int m_pre = 0;
    bit started = 0;

    always @(posedge clk) begin
        bit run;
        bit go;
        started = 1'b1;
        if (!rst_n) begin
            m_ctrl = 8'h00; m_tmr = 7; m_phase = 0;
            m_pending = 0; m_active = 0; m_idx = 0;
        end else begin
            run = m_ctrl[1];
            go  = run && !m_active && (m_pending || row_start) && (m_phase == 3);
            if (!run) begin
                m_active = 0; m_pending = 0; m_phase = 0;
            end else begin
                m_phase = (m_phase + 1) % 4;
                if (m_active) begin
                    if (m_idx == m_len - 1) m_active = 0;
                    else m_idx++;
                end else if (go) begin
                    m_active  = 1; m_idx = 0; m_pending = 0;
                    m_len     = (m_ctrl[2] ? (m_tmr + 2) : 35) * 4;
                    m_pre     = ((m_ctrl[5:4] == 2'b11) ? 3 : int'(m_ctrl[5:4]) + 1) * 4;
                end else if (row_start) begin
                    m_pending = 1;
                end
            end
            if (ctrl_wr) m_ctrl = ctrl_wdata;
            if (tmr_wr)  m_tmr  = int'(tmr_wdata[4:0]);
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            check(rot_active == m_active, "R3", "model rot_active", int'(rot_active), int'(m_active));
            check(precharge == (m_active && m_idx < m_pre), "R6", "model precharge",
                  int'(precharge), int'(m_active && m_idx < m_pre));
            check(rot_done == (m_active && m_idx == m_len - 1), "R10", "model rot_done",
                  int'(rot_done), int'(m_active && m_idx == m_len - 1));
            check(power_down == m_ctrl[0], "R8", "model power_down", int'(power_down), int'(m_ctrl[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_tmr(input logic [7:0] d);
        @(negedge clk); tmr_wr = 1'b1; tmr_wdata = d;
        @(negedge clk); tmr_wr = 1'b0;
    endtask

    // Strobe once, then measure latency, window length, precharge and done counts.
    // A second strobe is issued at window cycle strobe_at (0 = none).
    task automatic measure(input int strobe_at, output int lat, output int len,
                           output int pre, output int dn);
        lat = 0; len = 0; pre = 0; dn = 0;
        @(negedge clk); row_start = 1'b1;
        @(negedge clk); row_start = 1'b0;
        while (!rot_active && lat < 20) begin lat++; @(negedge clk); end
        while (rot_active && len < 400) begin
            len++;
            if (precharge) pre++;
            if (rot_done) dn++;
            row_start = (strobe_at != 0 && len == strobe_at);
            @(negedge clk);
        end
        row_start = 1'b0;
    endtask

    task automatic quiet_watch(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rot_active) seen++;
        end
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        int lat, len, pre, dn, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rot_active && !precharge && !rot_done && !power_down, "R1", "outputs after reset",
              int'({rot_active, precharge, rot_done, power_down}), 0);

        // R7: run bit clear, strobe does nothing
        measure(0, lat, len, pre, dn);
        check(len == 0, "R7", "window while held", len, 0);

        // R1 / R2 / R10: default length value in short mode
        wr_ctrl(8'h06);
        measure(0, lat, len, pre, dn);
        check(len == 36, "R1", "reset length window", len, 36);
        check(pre == 4, "R1", "reset precharge width", pre, 4);
        check(dn == 1, "R10", "done count", dn, 1);
        check(lat <= 3, "R2", "start latency", lat, 3);

        // R2: strobes at shifted phases
        for (int k = 0; k < 3; k++) begin
            repeat (k + 1) @(negedge clk);
            measure(0, lat, len, pre, dn);
            check(lat <= 3, "R2", "start latency shifted", lat, 3);
            check(len % 4 == 0, "R2", "length multiple of sensor clock", len % 4, 0);
        end

        // R4: long mode ignores length value
        wr_ctrl(8'h02);
        measure(0, lat, len, pre, dn);
        check(len == 140, "R4", "long window", len, 140);
        wr_tmr(8'h03);
        measure(0, lat, len, pre, dn);
        check(len == 140, "R4", "long window after length write", len, 140);

        // R3: short mode lengths
        wr_ctrl(8'h06);
        measure(0, lat, len, pre, dn);
        check(len == 20, "R3", "short N=3", len, 20);
        wr_tmr(8'h00);
        measure(0, lat, len, pre, dn);
        check(len == 8, "R3", "short N=0", len, 8);
        check(dn == 1, "R10", "done on minimum window", dn, 1);

        // R5: upper bits dropped
        wr_tmr(8'hFF);
        measure(0, lat, len, pre, dn);
        check(len == 132, "R5", "length write 0xFF", len, 132);
        wr_tmr(8'hE5);
        measure(0, lat, len, pre, dn);
        check(len == 28, "R5", "length write 0xE5", len, 28);
        wr_ctrl(8'hCE);
        measure(0, lat, len, pre, dn);
        check(len == 28 && pre == 4, "R5", "spare control bits", len * 100 + pre, 2804);
        check(!power_down, "R5", "spare bits vs power_down", int'(power_down), 0);

        // R6: precharge width codes
        for (int c = 0; c < 4; c++) begin
            int exp_pre;
            exp_pre = ((c == 3) ? 3 : c + 1) * 4;
            wr_ctrl(8'h06 | 8'(c << 4));
            measure(0, lat, len, pre, dn);
            check(pre == exp_pre, "R6", "precharge width", pre, exp_pre);
            check(len == 28, "R6", "length unchanged by width", len, 28);
        end

        // R8: power-down output
        wr_ctrl(8'h07);
        check(power_down == 1'b1, "R8", "power_down set", int'(power_down), 1);
        wr_ctrl(8'h06);
        check(power_down == 1'b0, "R8", "power_down clear", int'(power_down), 0);

        // R9: strobe during a window is dropped
        measure(10, lat, len, pre, dn);
        check(len == 28, "R9", "window with extra strobe", len, 28);
        quiet_watch(12, seen);
        check(seen == 0, "R9", "no follow-on window", seen, 0);

        // R11: writes in mid-window do not apply until next window
        fork
            measure(0, lat, len, pre, dn);
            begin
                repeat (8) @(negedge clk);
                tmr_wr = 1'b1; tmr_wdata = 8'd20;
                @(negedge clk); tmr_wr = 1'b0;
                ctrl_wr = 1'b1; ctrl_wdata = 8'h26;
                @(negedge clk); ctrl_wr = 1'b0;
            end
        join
        check(len == 28 && pre == 4, "R11", "window after mid writes", len * 100 + pre, 2804);
        measure(0, lat, len, pre, dn);
        check(len == 88 && pre == 12, "R11", "next window uses new settings", len * 100 + pre, 8812);

        // R7: abort by clearing run bit
        wr_ctrl(8'h02);
        fork
            measure(0, lat, len, pre, dn);
            begin
                repeat (20) @(negedge clk);
                ctrl_wr = 1'b1; ctrl_wdata = 8'h00;
                @(negedge clk); ctrl_wr = 1'b0;
            end
        join
        check(len < 140 && len > 0, "R7", "aborted window length", len, 140);
        check(dn == 0, "R7", "no done on abort", dn, 0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule